// File: doc/BRIEF.md
# Receive Ring DMA Completion Tag Checker

This block guards the consumer side of a receive descriptor ring against a race: the ring's write index and the DMA that fills an entry run independently, so the index can move ahead of the data. The producer side issues a sequence tag each time an entry's DMA completes. The tag is written into the entry together with the data. The consumer side holds its own expected tag and compares it with the tag it reads from the entry at its read position. It lets the entry through only when the two are equal.

Tags are 13 bits wide and never take the value zero. Both counters start at 1, count up, and go from 0x1FFF back to 1. A zero in an entry always means the entry has not been written yet. A configuration input turns tag checking off. When it is off, an entry is accepted as soon as the write index shows it, and the expected tag still advances, so the sequence stays aligned if checking is turned on again.

Top module: `rx_tag_guard`

## Requirements
- R1: After reset the producer tag output `prod_tag` and the consumer expected tag both equal 1.
- R2: Each cycle with `prod_done` high, `prod_tag` advances by one on the next clock edge. From 0x1FFF it goes to 1, never to 0.
- R3: When `cons_valid` is high, `chk_en` is high and `cons_tag` equals the expected tag, `cons_accept` is high in that same cycle (combinational) and `cons_stall` is low.
- R4: When `cons_valid` is high, `chk_en` is high and `cons_tag` differs from the expected tag, `cons_stall` is high, `cons_accept` is low, and the expected tag does not change.
- R5: A `cons_tag` of 0 never gives an accept while `chk_en` is high. This holds even at reset, when the expected tag is 1.
- R6: After each accept the expected tag advances by one with the same skip-zero wrap, from 0x1FFF to 1.
- R7: With `chk_en` low, every cycle with `cons_valid` high gives an accept, whatever `cons_tag` is, and still advances the expected tag.
- R8: With `cons_valid` low, both `cons_accept` and `cons_stall` are low and the expected tag holds.
- R9: `cons_accept` and `cons_stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Turns tag comparison on |
| prod_done | input | 1 | DMA completion strobe for one entry |
| prod_tag | output | 13 | Tag to write into the entry now completing |
| cons_valid | input | 1 | Write index shows an unread entry |
| cons_tag | input | 13 | Tag read from the entry at the read position |
| cons_accept | output | 1 | Entry consumed this cycle |
| cons_stall | output | 1 | Entry not yet written; retry |
| exp_tag | output | 13 | Consumer expected tag |

## Verification
The hardest case to reach is the wrap from 0x1FFF to 1, because it needs 8191 accepts first. The bench reaches it with a long run of back-to-back completions fed straight into the consumer, with random stale-tag stalls mixed in. It then checks that the tag after 0x1FFF is 1 on both sides and that a zero-valued entry stalls at that point too. Random toggling of `chk_en` shows that the expected tag stays in step with the producer through bypass phases.

// File: rtl/rx_tag_pkg.sv
package rx_tag_pkg;
  localparam int unsigned TAG_W = 13;
  typedef logic [TAG_W-1:0] tag_t;

  function automatic tag_t tag_next(input tag_t t);
    tag_t n;
    n = t + tag_t'(1);
    if (n == '0) n = tag_t'(1);
    return n;
  endfunction
endpackage

// File: rtl/rx_tag_seq.sv
module rx_tag_seq
  import rx_tag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output tag_t tag
);
  tag_t tag_q, tag_d;

  always_comb begin
    tag_d = tag_q;
    if (step) tag_d = tag_next(tag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= tag_t'(1);
    else if (step) tag_q <= tag_d;
  end

  assign tag = tag_q;
endmodule

// File: rtl/rx_tag_cmp.sv
module rx_tag_cmp
  import rx_tag_pkg::*;
(
  input  logic chk_en,
  input  logic valid,
  input  tag_t seen,
  input  tag_t expect_tag,
  output logic accept,
  output logic stall
);
  logic written, match;

  always_comb begin
    written = (seen != '0);
    match   = written && (seen == expect_tag);
    accept  = valid && (!chk_en || match);
    stall   = valid && chk_en && !match;
  end
endmodule

// File: rtl/rx_tag_guard.sv
module rx_tag_guard
  import rx_tag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             prod_done,
  output logic [TAG_W-1:0] prod_tag,
  input  logic             cons_valid,
  input  logic [TAG_W-1:0] cons_tag,
  output logic             cons_accept,
  output logic             cons_stall,
  output logic [TAG_W-1:0] exp_tag
);
  tag_t p_tag, c_tag;
  logic acc;

  rx_tag_seq u_prod (.clk(clk), .rst_n(rst_n), .step(prod_done), .tag(p_tag));
  rx_tag_seq u_cons (.clk(clk), .rst_n(rst_n), .step(acc),       .tag(c_tag));

  rx_tag_cmp u_cmp (
    .chk_en(chk_en), .valid(cons_valid), .seen(cons_tag),
    .expect_tag(c_tag), .accept(acc), .stall(cons_stall)
  );

  assign prod_tag    = p_tag;
  assign exp_tag     = c_tag;
  assign cons_accept = acc;
endmodule

// File: rtl/rx_tag_guard_chk.sv
module rx_tag_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_en,
  input logic        prod_done,
  input logic [12:0] prod_tag,
  input logic        cons_valid,
  input logic [12:0] cons_tag,
  input logic        cons_accept,
  input logic        cons_stall,
  input logic [12:0] exp_tag
);
  // R2
  tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_tag != 13'd0 && exp_tag != 13'd0);
  // R2
  prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_done |=> prod_tag == (($past(prod_tag) == 13'h1FFF) ? 13'd1 : $past(prod_tag) + 13'd1));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_stall |=> $stable(exp_tag));
  // R5
  zero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cons_tag == 13'd0) |-> !cons_accept);
  // R6
  exp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_accept |=> exp_tag == (($past(exp_tag) == 13'h1FFF) ? 13'd1 : $past(exp_tag) + 13'd1));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_valid |-> (!cons_accept && !cons_stall));
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cons_accept && cons_stall));
endmodule

bind rx_tag_guard rx_tag_guard_chk u_chk (.*);

// File: tb/rx_tag_guard_tb.sv
module rx_tag_guard_tb;
  logic clk = 0, rst_n = 0, chk_en = 0, prod_done = 0, cons_valid = 0;
  logic [12:0] cons_tag = 0;
  logic [12:0] prod_tag, exp_tag;
  logic cons_accept, cons_stall;
  int checks = 0, fails = 0;
  logic [12:0] m_prod, m_exp;

  always #2 clk = ~clk;

  rx_tag_guard u_dut (.*);

  function automatic logic [12:0] nxt(input logic [12:0] t);
    return (t == 13'h1FFF) ? 13'd1 : t + 13'd1;
  endfunction

  task automatic chk(input string r, input logic [12:0] act, input logic [12:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, expv);
    end
  endtask

  // drive at negedge, check comb outs mid-cycle, then advance model at posedge
  task automatic cyc(input logic en, input logic pd, input logic cv, input logic [12:0] ct, input string r);
    logic ea, es;
    @(negedge clk);
    chk_en = en; prod_done = pd; cons_valid = cv; cons_tag = ct;
    #1;
    ea = cv && (!en || (ct != 0 && ct == m_exp));
    es = cv && en && !(ct != 0 && ct == m_exp);
    chk(r, {12'd0, cons_accept}, {12'd0, ea});
    chk(r, {12'd0, cons_stall},  {12'd0, es});
    @(posedge clk);
    if (pd) m_prod = nxt(m_prod);
    if (ea) m_exp = nxt(m_exp);
    #1;
    chk("R2", prod_tag, m_prod);
    chk(ea ? "R6" : (es ? "R4" : "R8"), exp_tag, m_exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_prod = 1; m_exp = 1;
    #10 @(negedge clk) rst_n = 1;
    #1;
    // R1
    chk("R1", prod_tag, 13'd1);
    chk("R1", exp_tag, 13'd1);
    // R5 zero tag at reset
    cyc(1, 0, 1, 13'd0, "R5");
    // R3 match
    cyc(1, 1, 1, 13'd1, "R3");
    // R4 mismatch stale
    cyc(1, 0, 1, 13'd7, "R4");
    // R7 bypass
    cyc(0, 1, 1, 13'd0, "R7");
    cyc(0, 0, 1, 13'h155, "R7");
    // R8 idle
    cyc(1, 0, 0, 13'd3, "R8");
    // random mix, includes the wrap past 0x1FFF
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 9);
      logic en = (r != 0);
      logic [12:0] t;
      if (r < 6) t = m_exp;
      else if (r < 8) t = 13'd0;
      else t = 13'($urandom);
      cyc(en, 1'($urandom), $urandom_range(0, 7) != 0, t, "R3");
    end
    // directed wrap: drive consumer until exp at 0x1FFF
    while (m_exp != 13'h1FFF) cyc(0, 0, 1, 13'd0, "R7");
    cyc(1, 0, 1, 13'd0, "R5");
    cyc(1, 0, 1, 13'h1FFF, "R6");
    chk("R6", exp_tag, 13'd1);
    while (m_prod != 13'h1FFF) cyc(0, 1, 0, 13'd0, "R2");
    cyc(1, 1, 0, 13'd0, "R2");
    chk("R2", prod_tag, 13'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule